// File: doc/BRIEF.md
# AHB Line and Single-Access Bus Sequencer

This block is the control core of a bus master that serves two clients: a cache that moves whole lines, and the core pipeline, which issues single uncached reads and writes. In each idle cycle it picks at most one request. A line transfer becomes an incrementing AHB-Lite burst. An uncached access becomes one SINGLE transfer. The block drives the transfer-type, direction and burst-type lines, and it steps a beat index across the line for the address phase. A second copy of that index, one cycle later, names the beat whose data phase is on the bus.

Toward the cache, the block says when a beat of read data may be captured and in which slot. It also says when the line is complete, and when the cache must take its word from the beat index rather than from the core address. Toward the pipeline, it reports two things: that the bus is still busy, and that an interrupt must wait because a transfer is under way. Once a transfer has finished, the interrupt-blocking flag drops even if the pipeline is still stalled. No new transfer starts until that stall clears.

All pins are plain control lines. There is no valid/ready pair at the edge of this block. A request level is held by its client until the acknowledge or the stall release, and HREADY is the only back-pressure. Any cycle in which HREADY is low freezes the state, the counters and the transfer type.

Top module: `ahb_line_sequencer`

## Requirements
- R1: HTRANS is 2'b10 (NONSEQ) in the cycle a transfer starts, 2'b11 (SEQ) for every later address beat of a line, and 2'b00 (IDLE) otherwise; 2'b01 never appears.
- R2: The cache request code 2'b10 starts a line fetch (HWRITE low) and 2'b01 starts a line writeback (HWRITE high on each of its address beats). The uncached code 2'b10 is a read and 2'b01 is a write (HWRITE high in its address phase). Other codes request nothing. A cache request wins over an uncached one.
- R3: HBURST is 3'b011 (INCR4 for the default of 4 beats; 8 beats give 3'b101, 16 give 3'b111, any other length 3'b001) during line address beats, and 3'b000 (SINGLE) otherwise.
- R4: The address beat index is 0 when idle. It becomes 1 after the first beat is accepted, counts up by one per HREADY-high cycle, and returns to 0 after beat BEATS-1 is accepted. The delayed index takes the address index's value on every HREADY-high edge. The beat-select flag is high in the start cycle of a line and throughout the line's address and data phases.
- R5: While HREADY is low, the state, both indices and HTRANS hold their values.
- R6: While the flush input is high, no transfer starts (HTRANS never shows NONSEQ).
- R7: The busy output is high in a start cycle, during every line address beat, and in the final data phase until HREADY is high.
- R8: The committed output is high from the cycle after a transfer starts until its last data phase ends. It is low afterwards, even while the stall input is high.
- R9: The line acknowledge is high for exactly the cycle in which the last data beat of a line completes with HREADY high.
- R10: Capture enable is high only in data-phase cycles of a line fetch where HREADY is high.
- R11: If the stall input is high when a transfer completes, no new transfer starts until the stall input is low; the block then returns to idle.
- R12: With the read-only parameter set, a writeback request (2'b01) is ignored and only fetches are issued.
- R13: An active-low reset returns the block to idle with both indices at 0 and all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| hready | input | 1 | Slave ready; low inserts a wait state |
| flush | input | 1 | Pipeline flush; blocks the start of a transfer |
| stall | input | 1 | Pipeline stall; holds completion until released |
| cache_req | input | 2 | Cache line request: 01 writeback, 10 fetch |
| uc_req | input | 2 | Uncached request: 10 read, 01 write |
| htrans | output | 2 | AHB transfer type |
| hwrite | output | 1 | AHB direction, high for writes |
| hburst | output | 3 | AHB burst type |
| beat_cnt | output | $clog2(BEATS) | Beat index of the current address phase |
| beat_cnt_d | output | $clog2(BEATS) | Beat index of the current data phase |
| capture_en | output | 1 | Write the read data into the slot given by beat_cnt_d |
| sel_beat | output | 1 | Cache takes its word index from the beat index |
| line_ack | output | 1 | Line transfer finished |
| bus_stall | output | 1 | Bus busy; pipeline must wait |
| bus_committed | output | 1 | Transfer under way; interrupts must wait |

## Verification
HTRANS, HWRITE, HBURST, the beat-select flag and the busy output are due in the same cycle as the request or state that causes them, because the address phase is decoded combinationally. The indices and the state change one edge after an HREADY-high cycle. Acknowledge and capture enable follow HREADY within the same cycle of the last data phase. The bench drives inputs at the falling edge, compares every output against its own per-cycle model 1 ns later, and then moves that model forward at the rising edge, so each expected value is tied to the cycle in which it becomes due.

// File: rtl/ahbseq_pkg.sv
package ahbseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UC,
    ST_LINE,
    ST_LAST,
    ST_HOLD
  } seq_state_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  // request codes shared by cache and uncached ports
  localparam logic [1:0] REQ_WR = 2'b01;
  localparam logic [1:0] REQ_RD = 2'b10;

  localparam logic [2:0] BURST_SINGLE = 3'b000;

  function automatic logic [2:0] burst_code(input int beats);
    case (beats)
      4:       burst_code = 3'b011;
      8:       burst_code = 3'b101;
      16:      burst_code = 3'b111;
      default: burst_code = 3'b001;
    endcase
  endfunction

endpackage

// File: rtl/beat_track.sv
module beat_track #(
  parameter int BEATS = 4,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hready,
  input  logic             step,
  input  logic             wrap,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_d
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cnt_d <= '0;
    end else if (hready) begin
      cnt_d <= cnt;
      if (wrap)      cnt <= '0;
      else if (step) cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import ahbseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hready,
  input  logic       flush,
  input  logic       stall,
  input  logic [1:0] line_req,
  input  logic [1:0] uc_req,
  input  logic       last_beat,
  output seq_state_e state,
  output logic       start_line,
  output logic       start_uc,
  output logic       line_wr
);

  seq_state_e next;
  logic line_valid, uc_valid;

  always_comb begin
    line_valid = (line_req == REQ_RD) || (line_req == REQ_WR);
    uc_valid   = (uc_req == REQ_RD) || (uc_req == REQ_WR);
    start_line = (state == ST_IDLE) && !flush && line_valid;
    start_uc   = (state == ST_IDLE) && !flush && !line_valid && uc_valid;
    next = state;
    case (state)
      ST_IDLE: begin
        if (hready && start_line)    next = ST_LINE;
        else if (hready && start_uc) next = ST_UC;
      end
      ST_LINE: if (hready && last_beat) next = ST_LAST;
      ST_UC, ST_LAST: if (hready) next = stall ? ST_HOLD : ST_IDLE;
      ST_HOLD: if (!stall) next = ST_IDLE;
      default: next = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      line_wr <= 1'b0;
    end else begin
      state <= next;
      if (hready && start_line) line_wr <= (line_req == REQ_WR);
    end
  end

endmodule

// File: rtl/ahb_line_sequencer.sv
module ahb_line_sequencer
  import ahbseq_pkg::*;
#(
  parameter int BEATS     = 4,
  parameter bit READ_ONLY = 1'b0,
  localparam int CNT_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hready,
  input  logic             flush,
  input  logic             stall,
  input  logic [1:0]       cache_req,
  input  logic [1:0]       uc_req,
  output logic [1:0]       htrans,
  output logic             hwrite,
  output logic [2:0]       hburst,
  output logic [CNT_W-1:0] beat_cnt,
  output logic [CNT_W-1:0] beat_cnt_d,
  output logic             capture_en,
  output logic             sel_beat,
  output logic             line_ack,
  output logic             bus_stall,
  output logic             bus_committed
);

  localparam logic [CNT_W-1:0] LAST_IDX   = CNT_W'(BEATS - 1);
  localparam logic [2:0]       LINE_BURST = burst_code(BEATS);

  seq_state_e state;
  logic [1:0] line_req;
  logic       start_line, start_uc, line_wr, last_beat;
  logic       in_line, in_last, in_uc;

  // a read-only cache has no writeback path at all
  if (READ_ONLY) begin : g_ro
    assign line_req = (cache_req == REQ_RD) ? REQ_RD : 2'b00;
  end else begin : g_rw
    assign line_req = cache_req;
  end

  assign last_beat = (beat_cnt == LAST_IDX);

  seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hready     (hready),
    .flush      (flush),
    .stall      (stall),
    .line_req   (line_req),
    .uc_req     (uc_req),
    .last_beat  (last_beat),
    .state      (state),
    .start_line (start_line),
    .start_uc   (start_uc),
    .line_wr    (line_wr)
  );

  assign in_line = (state == ST_LINE);
  assign in_last = (state == ST_LAST);
  assign in_uc   = (state == ST_UC);

  beat_track #(.BEATS(BEATS)) u_beats (
    .clk   (clk),
    .rst_n (rst_n),
    .hready(hready),
    .step  (start_line || (in_line && !last_beat)),
    .wrap  (in_line && last_beat),
    .cnt   (beat_cnt),
    .cnt_d (beat_cnt_d)
  );

  always_comb begin
    if (start_line || start_uc) htrans = TR_NONSEQ;
    else if (in_line)           htrans = TR_SEQ;
    else                        htrans = TR_IDLE;
    hwrite = (start_line && line_req == REQ_WR) ||
             (start_uc && uc_req == REQ_WR) ||
             (in_line && line_wr);
    hburst        = (start_line || in_line) ? LINE_BURST : BURST_SINGLE;
    sel_beat      = start_line || in_line || in_last;
    capture_en    = (in_line || in_last) && !line_wr && hready;
    line_ack      = in_last && hready;
    bus_stall     = start_line || start_uc || in_line || ((in_uc || in_last) && !hready);
    bus_committed = in_uc || in_line || in_last;
  end

endmodule

// File: rtl/ahb_line_sequencer_chk.sv
module ahb_line_sequencer_chk #(
  parameter int BEATS     = 4,
  parameter bit READ_ONLY = 1'b0,
  localparam int CNT_W = $clog2(BEATS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hready,
  input logic             flush,
  input logic [1:0]       htrans,
  input logic             hwrite,
  input logic [2:0]       hburst,
  input logic [CNT_W-1:0] beat_cnt,
  input logic [CNT_W-1:0] beat_cnt_d,
  input logic             capture_en,
  input logic             sel_beat,
  input logic             line_ack,
  input logic             bus_stall,
  input logic             bus_committed
);

  p_htrans_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    htrans != 2'b01);

  p_single_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b10 && !sel_beat) |-> hburst == 3'b000);

  p_cnt_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> $stable(beat_cnt));

  p_cnt_delayed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hready |=> beat_cnt_d == $past(beat_cnt));

  p_seq_waits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11 && !hready) |=> htrans == 2'b11);

  p_flush_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> htrans != 2'b10);

  p_seq_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == 2'b11 |-> bus_stall);

  p_ack_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_ack |=> !bus_committed);

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_ack |=> !line_ack);

  p_capture_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |-> (hready && bus_committed));

  if (READ_ONLY) begin : g_ro_chk
    p_no_writeback_r12: assert property (@(posedge clk) disable iff (!rst_n)
      sel_beat |-> !hwrite);
  end

endmodule

bind ahb_line_sequencer ahb_line_sequencer_chk #(
  .BEATS(BEATS), .READ_ONLY(READ_ONLY)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hready       (hready),
  .flush        (flush),
  .htrans       (htrans),
  .hwrite       (hwrite),
  .hburst       (hburst),
  .beat_cnt     (beat_cnt),
  .beat_cnt_d   (beat_cnt_d),
  .capture_en   (capture_en),
  .sel_beat     (sel_beat),
  .line_ack     (line_ack),
  .bus_stall    (bus_stall),
  .bus_committed(bus_committed)
);

// File: tb/sim_ahb_line_sequencer.sv
module sim_ahb_line_sequencer;

  localparam int BEATS = 4;
  localparam int THR   = BEATS - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hready = 1'b0, flush = 1'b0, stall = 1'b0;
  logic [1:0] cache_req = 2'b00, uc_req = 2'b00, c1_req = 2'b00;

  logic [1:0] htrans;  logic hwrite;  logic [2:0] hburst;
  logic [1:0] beat_cnt, beat_cnt_d;
  logic capture_en, sel_beat, line_ack, bus_stall, bus_committed;

  logic [1:0] r_htrans;  logic r_hwrite;  logic [2:0] r_hburst;
  logic [1:0] r_cnt, r_cntd;
  logic r_cap, r_sel, r_ack, r_stall, r_comm;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model: 0 idle, 1 uncached data, 2 line beats, 3 last data, 4 hold
  int ms = 0, mcnt = 0, mcntd = 0;
  bit mwr = 1'b0;

  always #5 clk = ~clk;

  ahb_line_sequencer #(.BEATS(BEATS), .READ_ONLY(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .hready(hready), .flush(flush), .stall(stall),
    .cache_req(cache_req), .uc_req(uc_req),
    .htrans(htrans), .hwrite(hwrite), .hburst(hburst),
    .beat_cnt(beat_cnt), .beat_cnt_d(beat_cnt_d), .capture_en(capture_en),
    .sel_beat(sel_beat), .line_ack(line_ack), .bus_stall(bus_stall),
    .bus_committed(bus_committed));

  ahb_line_sequencer #(.BEATS(BEATS), .READ_ONLY(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .hready(hready), .flush(flush), .stall(stall),
    .cache_req(c1_req), .uc_req(2'b00),
    .htrans(r_htrans), .hwrite(r_hwrite), .hburst(r_hburst),
    .beat_cnt(r_cnt), .beat_cnt_d(r_cntd), .capture_en(r_cap),
    .sel_beat(r_sel), .line_ack(r_ack), .bus_stall(r_stall),
    .bus_committed(r_comm));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic bit valid_code(input logic [1:0] c);
    return (c == 2'b01) || (c == 2'b10);
  endfunction

  // one cycle: drive, compare with model, advance model at the edge
  task automatic step(input bit hr, input bit fl, input bit st,
                      input logic [1:0] cq, input logic [1:0] uq, input string note);
    bit sl, su;
    int o;
    @(negedge clk);
    hready = hr; flush = fl; stall = st; cache_req = cq; uc_req = uq;
    #1;
    sl = (ms == 0) && !fl && valid_code(cq);
    su = (ms == 0) && !fl && !sl && valid_code(uq);
    chk({"R1 htrans ", note}, 32'(htrans), (sl || su) ? 32'd2 : (ms == 2 ? 32'd3 : 32'd0));
    chk({"R2 hwrite ", note}, 32'(hwrite),
        32'((sl && cq == 2'b01) || (su && uq == 2'b01) || (ms == 2 && mwr)));
    chk({"R3 hburst ", note}, 32'(hburst), (sl || ms == 2) ? 32'd3 : 32'd0);
    chk({"R4 beat_cnt ", note}, 32'(beat_cnt), 32'(mcnt));
    chk({"R4 beat_cnt_d ", note}, 32'(beat_cnt_d), 32'(mcntd));
    chk({"R4 sel_beat ", note}, 32'(sel_beat), 32'(sl || ms == 2 || ms == 3));
    chk({"R7 bus_stall ", note}, 32'(bus_stall),
        32'(sl || su || ms == 2 || ((ms == 1 || ms == 3) && !hr)));
    chk({"R8 bus_committed ", note}, 32'(bus_committed), 32'(ms == 1 || ms == 2 || ms == 3));
    chk({"R9 line_ack ", note}, 32'(line_ack), 32'(ms == 3 && hr));
    chk({"R10 capture_en ", note}, 32'(capture_en), 32'((ms == 2 || ms == 3) && !mwr && hr));
    @(posedge clk);
    o = ms;
    if (hr) begin
      int prev_cnt;
      prev_cnt = mcnt;
      if (o == 0 && sl) begin ms = 2; mcnt = 1; mwr = (cq == 2'b01); end
      else if (o == 0 && su) ms = 1;
      else if (o == 2) begin
        if (mcnt == THR) begin ms = 3; mcnt = 0; end
        else mcnt = mcnt + 1;
      end
      else if (o == 1 || o == 3) ms = st ? 4 : 0;
      mcntd = prev_cnt;
    end
    if (o == 4 && !st) ms = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13 reset htrans", 32'(htrans), 0);
    chk("R13 reset beat_cnt", 32'(beat_cnt), 0);
    chk("R13 reset beat_cnt_d", 32'(beat_cnt_d), 0);
    chk("R13 reset bus_stall", 32'(bus_stall), 0);
    chk("R13 reset bus_committed", 32'(bus_committed), 0);
    chk("R13 reset line_ack", 32'(line_ack), 0);
    rst_n = 1'b1;

    // R6: flush holds off a pending fetch
    step(1, 1, 0, 2'b10, 2'b10, "R6");
    step(1, 1, 0, 2'b10, 2'b00, "R6");
    // R2/R9: full fetch with no wait states, ack in cycle BEATS
    for (int i = 0; i < BEATS + 1; i++) step(1, 0, 0, 2'b10, 2'b00, "R9 fetch");
    step(1, 0, 0, 2'b00, 2'b00, "idle");
    // R5: wait states inside a writeback burst
    step(1, 0, 0, 2'b01, 2'b10, "R2 priority");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 2'b01, 2'b00, "R5 wait");
    for (int i = 0; i < BEATS; i++) step(1, 0, 0, 2'b01, 2'b00, "R3 writeback");
    // R11: uncached read completes under stall
    step(1, 0, 1, 2'b00, 2'b10, "R11 start");
    step(1, 0, 1, 2'b00, 2'b10, "R11 done");
    step(1, 0, 1, 2'b10, 2'b01, "R11 held");
    step(1, 0, 1, 2'b10, 2'b01, "R11 held");
    step(1, 0, 0, 2'b00, 2'b00, "R11 release");
    step(1, 0, 0, 2'b00, 2'b01, "R2 uc write");
    step(0, 0, 0, 2'b00, 2'b00, "R7 uc wait");
    step(1, 0, 0, 2'b00, 2'b00, "R7 uc end");

    for (int n = 0; n < 4000; n++) begin
      int a, b;
      logic [1:0] cq, uq;
      a = $urandom % 4; b = $urandom % 4;
      cq = (a == 1) ? 2'b01 : (a == 2) ? 2'b10 : (a == 3) ? 2'b11 : 2'b00;
      uq = (b == 1) ? 2'b01 : (b == 2) ? 2'b10 : 2'b00;
      step(($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 3) == 0, cq, uq, "rand");
    end
    for (int i = 0; i < BEATS + 3; i++) step(1, 0, 0, 2'b00, 2'b00, "drain");

    // R12: read-only instance ignores writeback, still fetches
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      hready = 1'b1; flush = 1'b0; stall = 1'b0; cache_req = 2'b00; uc_req = 2'b00;
      c1_req = 2'b01;
      #1;
      chk("R12 ro writeback htrans", 32'(r_htrans), 0);
      chk("R12 ro writeback bus_stall", 32'(r_stall), 0);
      chk("R12 ro writeback hwrite", 32'(r_hwrite), 0);
    end
    @(negedge clk);
    c1_req = 2'b10;
    #1;
    chk("R12 ro fetch htrans", 32'(r_htrans), 2);
    chk("R12 ro fetch hburst", 32'(r_hburst), 3);
    @(negedge clk);
    c1_req = 2'b00;
    report();
  end

endmodule